// File: doc/BRIEF.md
# Single-Step Shifter with Status Flags

This block is the shift section of a small microcontroller datapath. It moves an 8-bit operand one place in a single cycle, either left with a zero fill, right with a zero fill, or right while keeping the sign bit. Alongside the shifted value it produces five status flags: carry, negative, two's-complement overflow, zero and sign. Overflow is always the exclusive OR of negative and carry, as they stand after the shift. Because of this, it means something different for each shift kind. After a left shift it shows that the top two operand bits differed. After a logical right shift it simply equals the carry. After an arithmetic right shift it marks a negative even operand or a non-negative odd one.

The default build registers its outputs. Result and flags are loaded into a status register on a rising clock edge while the write enable is high. A parameter selects a purely combinational build instead. The fourth operation code is reserved. It passes the operand through unchanged and leaves the stored flags as they were.

Top module: `shift_unit`

## Requirements
- R1: With op_i = 2'b00 (left shift), the result is the operand moved one place toward the MSB with bit 0 filled by 0, and C is the operand's old bit 7.
- R2: With op_i = 2'b01 (logical right shift), the result is the operand moved one place toward the LSB with bit 7 filled by 0, N is 0 and C is the operand's old bit 0.
- R3: With op_i = 2'b10 (arithmetic right shift), the result keeps the operand's bit 7 in bit 7 and holds operand bits 7..1 in bits 6..0, and C is the operand's old bit 0.
- R4: For the left shift and the arithmetic right shift, N equals bit 7 of the result.
- R5: For all three shifts, V equals N XOR C. In particular, after a left shift V is 1 exactly when operand bits 7 and 6 differ.
- R6: Z is 1 exactly when all 8 result bits are 0, for every shift.
- R7: S equals N XOR V.
- R8: With op_i = 2'b11 (reserved), a write loads the unshifted operand as the result and leaves every flag at its previous value.
- R9: While wr_en_i is low, result and flags hold their values across clock edges.
- R10: A synchronous active-high reset clears the result and all flags to 0 on the next rising edge. Outputs change one rising edge after a write.
- R11: flags_o packs the flags as bit 0 = C, bit 1 = Z, bit 2 = N, bit 3 = V, bit 4 = S.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 2 | Operation select: 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| opnd_i | input | 8 | Operand |
| wr_en_i | input | 1 | Loads result and flags on the clock edge |
| res_o | output | 8 | Shifted result |
| flags_o | output | 5 | {S, V, N, Z, C} |

## Verification
Every one of the 256 operand values is driven through each of the three shifts. This covers all four combinations of the top two bits, which separates overflow-set from overflow-clear after a left shift. It also covers negative and non-negative operands with both low-bit values, which exercises all four overflow cases of the arithmetic right shift. Zero results are reached by operands 0x00, 0x80 and 0x01. Reserved writes are interleaved after writes that set distinct flag patterns, so that a pass-through that disturbed the flags would be visible. Idle cycles and a mid-run reset separate holding from clearing.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_LEFT = 2'b00,
    SH_LRIGHT = 2'b01,
    SH_ARIGHT = 2'b10,
    SH_RSVD = 2'b11
  } shift_op_e;

  localparam int FLAG_C = 0;
  localparam int FLAG_Z = 1;
  localparam int FLAG_N = 2;
  localparam int FLAG_V = 3;
  localparam int FLAG_S = 4;
  localparam int FLAG_W = 5;
endpackage

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shift_op_e        op,
  input  logic [WIDTH-1:0] opnd,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    unique case (op)
      SH_LEFT:   res = {opnd[WIDTH-2:0], 1'b0};
      SH_LRIGHT: res = {1'b0, opnd[WIDTH-1:1]};
      SH_ARIGHT: res = {opnd[WIDTH-1], opnd[WIDTH-1:1]};
      default:   res = opnd;
    endcase
  end

  // R3: the sign bit survives an arithmetic right shift
  always_comb begin
    if (op == SH_ARIGHT) begin
      a_r3_sign_kept: assert (res[WIDTH-1] == opnd[WIDTH-1]);
    end
  end
endmodule

// File: rtl/shift_flags.sv
module shift_flags
  import shift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  shift_op_e         op,
  input  logic [WIDTH-1:0]  opnd,
  input  logic [WIDTH-1:0]  res,
  output logic [FLAG_W-1:0] flags
);
  logic c, n, v;

  always_comb begin
    c = (op == SH_LEFT) ? opnd[WIDTH-1] : opnd[0];
    n = (op == SH_LRIGHT) ? 1'b0 : res[WIDTH-1];
    v = n ^ c;
    flags = '0;
    if (op != SH_RSVD) begin
      flags[FLAG_C] = c;
      flags[FLAG_N] = n;
      flags[FLAG_V] = v;
      flags[FLAG_Z] = ~|res;
      flags[FLAG_S] = n ^ v;
    end
  end

  // R5: a left shift overflows exactly when the top two operand bits differ
  always_comb begin
    if (op == SH_LEFT) begin
      a_r5_left_ovf: assert (flags[FLAG_V] == (opnd[WIDTH-1] ^ opnd[WIDTH-2]));
    end
  end
endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_i,
  input  logic [WIDTH-1:0]  opnd_i,
  input  logic              wr_en_i,
  output logic [WIDTH-1:0]  res_o,
  output logic [FLAG_W-1:0] flags_o
);
  shift_op_e         op;
  logic [WIDTH-1:0]  nxt_res;
  logic [FLAG_W-1:0] nxt_flags;

  assign op = shift_op_e'(op_i);

  shift_core #(.WIDTH(WIDTH)) u_core (
    .op   (op),
    .opnd (opnd_i),
    .res  (nxt_res)
  );

  shift_flags #(.WIDTH(WIDTH)) u_flags (
    .op    (op),
    .opnd  (opnd_i),
    .res   (nxt_res),
    .flags (nxt_flags)
  );

  generate
    if (REGISTERED) begin : g_reg
      logic [WIDTH-1:0]  res_q;
      logic [FLAG_W-1:0] flags_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          res_q   <= '0;
          flags_q <= '0;
        end else if (wr_en_i) begin
          res_q <= nxt_res;
          if (op != SH_RSVD) flags_q <= nxt_flags;
        end
      end

      assign res_o   = res_q;
      assign flags_o = flags_q;

      // R5: stored overflow agrees with stored negative and carry
      a_r5_v_is_n_xor_c: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en_i && !rst && op_i != 2'b11)
        |-> flags_o[FLAG_V] == (flags_o[FLAG_N] ^ flags_o[FLAG_C]));

      // R6: stored zero flag agrees with stored result
      a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en_i && !rst && op_i != 2'b11)
        |-> flags_o[FLAG_Z] == (res_o == '0));

      // R8: reserved op passes the operand and keeps flags
      a_r8_rsvd_pass: assert property (@(posedge clk) disable iff (rst)
        $past(wr_en_i && !rst && op_i == 2'b11)
        |-> $stable(flags_o) && res_o == $past(opnd_i));

      // R9: no write, no change
      a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        $past(!wr_en_i && !rst) |-> $stable(res_o) && $stable(flags_o));

      // R10: reset leaves everything clear
      a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> res_o == '0 && flags_o == '0);
    end else begin : g_comb
      assign res_o   = nxt_res;
      assign flags_o = nxt_flags;
    end
  endgenerate
endmodule

// File: tb/shift_unit_bench.sv
module shift_unit_bench;
  typedef struct {
    logic [7:0] res;
    logic [4:0] flg;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] op_i = 2'b00;
  logic [7:0] opnd_i = 8'h00;
  logic       wr_en_i = 1'b0;
  logic [7:0] res_o;
  logic [4:0] flags_o;

  item_t      q[$];
  int         n_checks = 0;
  int         n_fails = 0;
  bit         done = 1'b0;
  logic [7:0] m_res = 8'h00;
  logic [4:0] m_flg = 5'h00;

  always #2 clk = ~clk;

  shift_unit u_shift_unit (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .opnd_i  (opnd_i),
    .wr_en_i (wr_en_i),
    .res_o   (res_o),
    .flags_o (flags_o)
  );

  task automatic drive(input logic r, input logic we, input logic [1:0] op,
                       input logic [7:0] a, input string tag);
    logic [7:0] res;
    logic c, n, v;
    item_t it;
    @(negedge clk);
    rst = r; wr_en_i = we; op_i = op; opnd_i = a;
    if (r) begin
      m_res = 8'h00; m_flg = 5'h00;
    end else if (we) begin
      case (op)
        2'b00: begin res = {a[6:0], 1'b0}; c = a[7]; n = res[7]; end
        2'b01: begin res = {1'b0, a[7:1]}; c = a[0]; n = 1'b0; end
        2'b10: begin res = {a[7], a[7:1]}; c = a[0]; n = res[7]; end
        default: begin res = a; c = 1'b0; n = 1'b0; end
      endcase
      m_res = res;
      if (op != 2'b11) begin
        v = n ^ c;
        m_flg = {n ^ v, v, n, (res == 8'h00), c};
      end
    end
    @(posedge clk);
    it.res = m_res; it.flg = m_flg; it.tag = tag;
    q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_checks++;
      if (res_o !== it.res || flags_o !== it.flg) begin
        n_fails++;
        $display("FAIL %s: got res=%02h flags=%05b, expected res=%02h flags=%05b",
                 it.tag, res_o, flags_o, it.res, it.flg);
      end
    end
  end

  initial begin
    drive(1'b1, 1'b0, 2'b00, 8'h00, "R10 reset state");
    drive(1'b1, 1'b0, 2'b00, 8'h00, "R10 reset state");
    for (int op = 0; op < 3; op++) begin
      for (int a = 0; a < 256; a++) begin
        case (op)
          0: drive(1'b0, 1'b1, 2'(op), 8'(a), "R1 R4 R5 R6 R7 R11 left");
          1: drive(1'b0, 1'b1, 2'(op), 8'(a), "R2 R5 R6 R7 R11 lright");
          default: drive(1'b0, 1'b1, 2'(op), 8'(a), "R3 R4 R5 R6 R7 R11 aright");
        endcase
      end
    end
    // reserved op after distinct flag patterns
    drive(1'b0, 1'b1, 2'b00, 8'h40, "R5 left ovf");
    drive(1'b0, 1'b1, 2'b11, 8'h5A, "R8 reserved keeps flags");
    drive(1'b0, 1'b1, 2'b01, 8'h01, "R2 R6 zero");
    drive(1'b0, 1'b1, 2'b11, 8'hC3, "R8 reserved keeps flags");
    drive(1'b0, 1'b1, 2'b10, 8'h80, "R3 neg even");
    drive(1'b0, 1'b1, 2'b11, 8'h00, "R8 reserved zero operand");
    // idle cycles
    drive(1'b0, 1'b0, 2'b00, 8'hFF, "R9 hold");
    drive(1'b0, 1'b0, 2'b10, 8'h01, "R9 hold");
    drive(1'b0, 1'b1, 2'b10, 8'h81, "R3 neg odd");
    drive(1'b0, 1'b0, 2'b11, 8'h7E, "R9 hold");
    // reset in mid run
    drive(1'b1, 1'b1, 2'b00, 8'hC0, "R10 reset beats write");
    drive(1'b0, 1'b0, 2'b00, 8'h00, "R9 R10 hold after reset");
    drive(1'b0, 1'b1, 2'b11, 8'h33, "R8 R10 reserved after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule